// File: doc/BRIEF.md
# Serial 1101 Sequence Spotter

This block watches a serial bit stream, one bit per accepted transfer, and raises a flag in the same cycle as the bit that ends the sequence 1101. It is a four-state Mealy machine. The flag depends on both the current state and the bit now offered. Matches may overlap: the final 1 of one match can start the next one. A run of extra ones ahead of the 10 still counts, because the machine keeps whatever tail of the stream is still useful after a wrong bit.

Bits arrive on a valid/ready input. The block never applies back-pressure, so `bit_ready` is always high and a bit is accepted on every cycle in which `bit_valid` is high. Cycles with `bit_valid` low are gaps. They leave the match progress unchanged and cannot raise the flag. The flag `hit` is a plain, unregistered status pin. A consumer that wants it aligned to a clock edge samples it on the same edge that accepts the bit.

Top module: `serial_pattern_spotter`

## Requirements
- R1: A synchronous active-high reset `rst` returns the machine to its empty state, where nothing is matched. `hit` reads 0 in every cycle in which `rst` is high, whatever the input bit is.
- R2: The state code is two bits: empty=00, one-seen=01, "11"-seen=10, "110"-seen=11. An accepted 1 moves empty to one-seen and one-seen to "11"-seen. An accepted 0 moves "11"-seen to "110"-seen.
- R3: An accepted 0 in the empty, one-seen or "110"-seen state sends the machine to the empty state.
- R4: An accepted 1 in the "11"-seen state keeps the machine in "11"-seen, so any run of two or more ones followed by 01 is detected.
- R5: An accepted 1 in the "110"-seen state completes a match and moves the machine to one-seen, so overlapping matches are reported. The stream 1101101 gives hits on its 4th and 7th bits.
- R6: `hit` is 1 exactly when the machine is in "110"-seen, `bit_valid` is 1, `bit_in` is 1 and `rst` is 0. It is combinational and valid in the cycle of the completing bit.
- R7: A cycle with `bit_valid` low changes no state, and `hit` is 0 in that cycle. Gaps of any length between the bits of a match do not prevent detection.
- R8: `bit_ready` is 1 in every cycle. The block never stalls its source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | The source offers a bit this cycle |
| bit_ready | output | 1 | Always 1; the offered bit is taken |
| bit_in | input | 1 | Serial data bit |
| hit | output | 1 | High in the cycle whose accepted bit completes 1101 |

## Verification
The bound checker watches individual transitions on every cycle:
- the state returns to empty after a reset edge;
- the empty state goes to one-seen on a 1;
- the "11"-seen state holds on further ones;
- a hit lands the machine in one-seen;
- the state holds through gaps;
- `hit` never rises without an accepted 1 or while reset is high.

Only the bench's scenarios can show end-to-end behaviour. They compare the flag against a model that simply looks at the last accepted bits. This covers:
- the cycle in which each hit appears;
- overlapping matches;
- runs of ones;
- recovery after wrong bits;
- gaps in the stream;
- a reset in mid-pattern.

// File: rtl/spotter_pkg.sv
package spotter_pkg;
  localparam int unsigned ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_EMPTY = 2'b00,
    ST_ONE   = 2'b01,
    ST_TWO   = 2'b10,
    ST_TRI   = 2'b11
  } spot_state_e;
endpackage

// File: rtl/spotter_next_state.sv
module spotter_next_state
  import spotter_pkg::*;
(
  input  spot_state_e cur_st,
  input  logic        take,
  input  logic        din,
  output spot_state_e nxt_st
);
  always_comb begin
    nxt_st = cur_st;
    if (take) begin
      unique case (cur_st)
        ST_EMPTY: nxt_st = din ? ST_ONE : ST_EMPTY;
        ST_ONE:   nxt_st = din ? ST_TWO : ST_EMPTY;
        ST_TWO:   nxt_st = din ? ST_TWO : ST_TRI;
        ST_TRI:   nxt_st = din ? ST_ONE : ST_EMPTY;
        default:  nxt_st = ST_EMPTY;
      endcase
    end
  end
endmodule

// File: rtl/spotter_hit_logic.sv
module spotter_hit_logic
  import spotter_pkg::*;
(
  input  spot_state_e cur_st,
  input  logic        take,
  input  logic        din,
  input  logic        rst,
  output logic        hit
);
  always_comb begin
    hit = 1'b0;
    if (!rst && take && din && (cur_st == ST_TRI)) hit = 1'b1;
  end
endmodule

// File: rtl/spotter_state_reg.sv
module spotter_state_reg
  import spotter_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  spot_state_e nxt_st,
  output spot_state_e cur_st
);
  always_ff @(posedge clk) begin
    if (rst) cur_st <= ST_EMPTY;
    else     cur_st <= nxt_st;
  end
endmodule

// File: rtl/serial_pattern_spotter.sv
module serial_pattern_spotter
  import spotter_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  output logic bit_ready,
  input  logic bit_in,
  output logic hit
);
  spot_state_e st_q;
  spot_state_e st_d;
  logic        take;

  // R8: no back-pressure, every offered bit is accepted
  assign bit_ready = 1'b1;
  assign take      = bit_valid & bit_ready;

  spotter_next_state u_next (
    .cur_st (st_q),
    .take   (take),
    .din    (bit_in),
    .nxt_st (st_d)
  );

  spotter_hit_logic u_hit (
    .cur_st (st_q),
    .take   (take),
    .din    (bit_in),
    .rst    (rst),
    .hit    (hit)
  );

  spotter_state_reg u_reg (
    .clk    (clk),
    .rst    (rst),
    .nxt_st (st_d),
    .cur_st (st_q)
  );
endmodule

// File: rtl/serial_pattern_spotter_checker.sv
module serial_pattern_spotter_checker
  import spotter_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        bit_valid,
  input logic        bit_in,
  input logic        hit,
  input spot_state_e st
);
  a_r1_reset_to_empty: assert property (@(posedge clk) rst |=> st == ST_EMPTY);
  a_r1_quiet_in_reset: assert property (@(posedge clk) rst |-> !hit);
  a_r2_empty_takes_one: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EMPTY && bit_valid && bit_in) |=> st == ST_ONE);
  a_r4_ones_hold_two: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TWO && bit_valid && bit_in) |=> st == ST_TWO);
  a_r5_match_reenters_one: assert property (@(posedge clk) disable iff (rst)
    hit |=> st == ST_ONE);
  a_r6_hit_needs_one: assert property (@(posedge clk) disable iff (rst)
    hit |-> (bit_valid && bit_in));
  a_r7_gap_holds: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(st));
endmodule

bind serial_pattern_spotter serial_pattern_spotter_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_valid (bit_valid),
  .bit_in    (bit_in),
  .hit       (hit),
  .st        (st_q)
);

// File: tb/serial_pattern_spotter_test.sv
`timescale 1ns/1ps
module serial_pattern_spotter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic bit_ready;
  logic hit;

  int total = 0;
  int bad = 0;
  int hits_seen = 0;
  logic [2:0] hist = 3'b000;

  always #2.5 clk = ~clk;

  serial_pattern_spotter uut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .bit_in(bit_in), .hit(hit)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive after the falling edge, check before the rising edge
  task automatic step(input logic r, input logic v, input logic b, input string tag);
    logic exp;
    @(negedge clk);
    rst = r; bit_valid = v; bit_in = b;
    #1;
    exp = !r && v && b && (hist == 3'b110);
    check(hit, exp, tag);
    check(bit_ready, 1'b1, "R8");
    if (hit === 1'b1) hits_seen++;
    if (r) hist = 3'b000;
    else if (v) hist = {hist[1:0], b};
  endtask

  task automatic feed(input string bits, input string tag);
    for (int i = 0; i < bits.len(); i++)
      step(1'b0, 1'b1, bits[i] == "1", tag);
  endtask

  task automatic t_reset();
    step(1'b1, 1'b1, 1'b1, "R1");
    step(1'b1, 1'b0, 1'b0, "R1");
    step(1'b0, 1'b0, 1'b0, "R1");
    feed("1", "R1");
  endtask

  task automatic t_basic();
    hits_seen = 0;
    feed("0001101", "R2 R6");
    check(hits_seen == 1, 1'b1, "R6 hit count");
  endtask

  task automatic t_overlap();
    step(1'b1, 1'b0, 1'b0, "R1");
    hits_seen = 0;
    feed("1101101", "R5");
    check(hits_seen == 2, 1'b1, "R5 overlap count");
  endtask

  task automatic t_mismatch();
    hits_seen = 0;
    feed("0010100110011100", "R3");
    check(hits_seen == 0, 1'b1, "R3 no false hit");
    feed("1101", "R3");
    check(hits_seen == 1, 1'b1, "R3 recovers");
  endtask

  task automatic t_run_ones();
    hits_seen = 0;
    feed("0111111101", "R4");
    check(hits_seen == 1, 1'b1, "R4 run of ones");
  endtask

  task automatic t_gaps();
    hits_seen = 0;
    feed("0", "R7");
    step(1'b0, 1'b1, 1'b1, "R7");
    step(1'b0, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b1, "R7");
    step(1'b0, 1'b0, 1'b1, "R7");
    step(1'b0, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, "R7");
    step(1'b0, 1'b0, 1'b1, "R7");
    check(hits_seen == 0, 1'b1, "R7 gap never hits");
    step(1'b0, 1'b1, 1'b1, "R7");
    check(hits_seen == 1, 1'b1, "R7 match across gaps");
  endtask

  task automatic t_mid_reset();
    hits_seen = 0;
    feed("0110", "R1");
    step(1'b1, 1'b1, 1'b1, "R1");
    feed("1", "R1");
    check(hits_seen == 0, 1'b1, "R1 reset clears progress");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_overlap();
    t_mismatch();
    t_run_ones();
    t_gaps();
    t_mid_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule